// File: doc/BRIEF.md
# On-Die SEC Read-Modify-Write Engine

This block is the internal error-correction path of a memory device whose protected word is twice as wide as a host access. Each stored block holds 128 data bits and 8 Hamming check bits. The 136-bit codeword corrects any one flipped bit. A host read always fetches the whole codeword, repairs it if needed, and returns only the 64-bit half it asked for. A host write turns into a read-modify-write: fetch the old codeword, repair it, splice in the new half, recompute the check bits, and store all 136 bits again.

The host side is a single request port with a ready signal and a one-cycle response strobe. The storage side drives a plain synchronous array: a read strobe whose data returns one cycle later, and a write strobe that carries a full codeword. While an access is in flight the block drops ready and takes no further requests. A one-cycle pulse reports each corrected bit. A separate pulse reports a syndrome that names no bit position.

Top module: `odsec_rmw`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1 and `rsp_valid`, `corr_evt`, `uncorr_evt`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: Codeword bit i stands for Hamming position i+1, where positions run from 1 to 136. Check bit k sits at bit index 2^k-1. Data bit j fills the j-th position, counting upward, that is not a power of two. The check bits make the XOR of the positions of all set bits equal zero. So data 0x1 in the lower half of an all-zero block is stored as 0x7, and data 0x11 is stored as 0x186.
- R3: A read is accepted on a rising edge while `req_valid` and `req_ready` are both 1. In the next cycle `mem_rd_en` is 1 and `mem_addr` equals `req_addr[BLK_AW:1]`. After the second rising edge that follows acceptance, `rsp_valid` is 1 for one cycle. `rsp_rdata` then carries data bits 127:64 when `req_addr[0]` is 1, and bits 63:0 otherwise.
- R4: A write issues the same fetch as a read. `mem_wr_en` is 1 for one cycle, two cycles after the fetch, and writes the full re-encoded codeword. The addressed half takes the new data and the other half keeps its old value.
- R5: A single flipped bit anywhere in the fetched codeword, data or check, is repaired before the data is returned. `corr_evt` pulses for exactly one cycle together with the response.
- R6: On a write, a single-bit error in the fetched word is repaired before the merge, so the stored word is clean. `corr_evt` pulses together with `mem_wr_en`, and later reads of both halves show no correction.
- R7: A nonzero syndrome above 136 pulses `uncorr_evt` and does not pulse `corr_evt`. The data is then passed on uncorrected. For example, flipping bit indices 127 and 8 of a zero block gives syndrome 137, and a lower-half read returns 0x10.
- R8: While `req_ready` is 0, `req_valid` has no effect. No extra fetch or write-back happens, and the stored data stays unchanged.
- R9: After a read is accepted, `req_ready` is 0 for two cycles. After a write is accepted, it is 0 for three cycles, which makes back-to-back writes slower than back-to-back reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BLK_AW+1 | Block address in the upper bits; bit 0 selects the upper half |
| req_wdata | input | HALF_W | Write data for the addressed half |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | HALF_W | Read data for the selected half |
| corr_evt | output | 1 | A single-bit error was repaired |
| uncorr_evt | output | 1 | Syndrome names no bit position |
| mem_rd_en | output | 1 | Array read strobe; data returns next cycle |
| mem_wr_en | output | 1 | Array write strobe |
| mem_addr | output | BLK_AW | Array block address |
| mem_wdata | output | 2*HALF_W+CHK_W | Codeword to store |
| mem_rdata | input | 2*HALF_W+CHK_W | Codeword returned by the array |

## Verification
Properties checked on every cycle:
- the fetch strobe follows each acceptance, and write-back comes two cycles after a fetch;
- the two array strobes are never active together;
- the array address holds steady while busy, and ready returns right after write-back;
- correction pulses last one cycle, appear only with a response or a write-back, and never coincide with the uncorrectable flag.

Properties only the bench scenarios can show:
- the exact stored bit layout;
- that a flipped bit in any position comes back repaired;
- that the half not being written survives a write;
- that a request raised while busy leaves the stored data alone.

// File: rtl/odsec_pkg.sv
package odsec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2,
        ST_WBACK = 2'd3
    } odsec_state_e;

    // Hamming position (1-based) of data bit idx: the idx-th non-power-of-two.
    function automatic int odsec_data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 3; p < 1024; p++) begin
            if (res == 0 && (p & (p - 1)) != 0) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/odsec_syndrome.sv
module odsec_syndrome #(
    parameter int CW_W  = 136,
    parameter int CHK_W = 8
) (
    input  logic [CW_W-1:0]  word_i,
    output logic [CHK_W-1:0] syn_o
);

    // XOR of the 1-based positions of every set bit.
    always_comb begin
        syn_o = '0;
        for (int p = 0; p < CW_W; p++) begin
            if (word_i[p]) syn_o = syn_o ^ CHK_W'(p + 1);
        end
    end

endmodule

// File: rtl/odsec_encoder.sv
module odsec_encoder
    import odsec_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int CHK_W  = 8
) (
    input  logic [DATA_W-1:0]       data_i,
    output logic [DATA_W+CHK_W-1:0] cw_o
);

    localparam int CW_W = DATA_W + CHK_W;

    logic [CW_W-1:0]  raw;
    logic [CHK_W-1:0] syn;

    // Scatter data into non-power-of-two positions.
    for (genvar g = 0; g < DATA_W; g++) begin : g_place
        localparam int POS = odsec_data_pos(g);
        assign raw[POS-1] = data_i[g];
    end

    // Check positions start out cleared.
    for (genvar k = 0; k < CHK_W; k++) begin : g_zero
        assign raw[(1 << k) - 1] = 1'b0;
    end

    odsec_syndrome #(
        .CW_W  (CW_W),
        .CHK_W (CHK_W)
    ) u_syn (
        .word_i (raw),
        .syn_o  (syn)
    );

    // Each check bit cancels its syndrome bit.
    always_comb begin
        cw_o = raw;
        for (int k = 0; k < CHK_W; k++) begin
            cw_o[(1 << k) - 1] = syn[k];
        end
    end

endmodule

// File: rtl/odsec_decoder.sv
module odsec_decoder
    import odsec_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int CHK_W  = 8
) (
    input  logic [DATA_W+CHK_W-1:0] cw_i,
    output logic [DATA_W-1:0]       data_o,
    output logic                    corr_o,
    output logic                    unc_o
);

    localparam int CW_W = DATA_W + CHK_W;

    logic [CHK_W-1:0] syn;
    logic [CW_W-1:0]  flip;
    logic [CW_W-1:0]  fixed;

    odsec_syndrome #(
        .CW_W  (CW_W),
        .CHK_W (CHK_W)
    ) u_syn (
        .word_i (cw_i),
        .syn_o  (syn)
    );

    // One-hot mask of the position the syndrome names, if any.
    always_comb begin
        for (int p = 0; p < CW_W; p++) begin
            flip[p] = (syn == CHK_W'(p + 1));
        end
        fixed  = cw_i ^ flip;
        corr_o = |flip;
        unc_o  = (|syn) && !(|flip);
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_pick
        localparam int POS = odsec_data_pos(g);
        assign data_o[g] = fixed[POS-1];
    end

endmodule

// File: rtl/odsec_rmw.sv
module odsec_rmw
    import odsec_pkg::*;
#(
    parameter int HALF_W = 64,
    parameter int CHK_W  = 8,
    parameter int BLK_AW = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic                           req_write,
    input  logic [BLK_AW:0]                req_addr,
    input  logic [HALF_W-1:0]              req_wdata,
    output logic                           rsp_valid,
    output logic [HALF_W-1:0]              rsp_rdata,
    output logic                           corr_evt,
    output logic                           uncorr_evt,
    output logic                           mem_rd_en,
    output logic                           mem_wr_en,
    output logic [BLK_AW-1:0]              mem_addr,
    output logic [2*HALF_W+CHK_W-1:0]      mem_wdata,
    input  logic [2*HALF_W+CHK_W-1:0]      mem_rdata
);

    localparam int DATA_W = 2 * HALF_W;
    localparam int CW_W   = DATA_W + CHK_W;

    typedef struct packed {
        odsec_state_e        st;
        logic                wr;
        logic                upper;
        logic [BLK_AW-1:0]   blk;
        logic [HALF_W-1:0]   wdata;
        logic                rd_en;
        logic                wr_en;
        logic [CW_W-1:0]     cw_out;
        logic                rsp_valid;
        logic [HALF_W-1:0]   rsp_data;
        logic                corr;
        logic                unc;
    } ctl_t;

    ctl_t q, d;

    logic [DATA_W-1:0] dec_data;
    logic [DATA_W-1:0] merged;
    logic              dec_corr;
    logic              dec_unc;
    logic [CW_W-1:0]   enc_cw;

    odsec_decoder #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W)
    ) u_dec (
        .cw_i   (mem_rdata),
        .data_o (dec_data),
        .corr_o (dec_corr),
        .unc_o  (dec_unc)
    );

    // Repaired old word with the new half spliced in.
    always_comb begin
        if (q.upper) merged = {q.wdata, dec_data[HALF_W-1:0]};
        else         merged = {dec_data[DATA_W-1:HALF_W], q.wdata};
    end

    odsec_encoder #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W)
    ) u_enc (
        .data_i (merged),
        .cw_o   (enc_cw)
    );

    always_comb begin
        d           = q;
        d.rd_en     = 1'b0;
        d.wr_en     = 1'b0;
        d.rsp_valid = 1'b0;
        d.corr      = 1'b0;
        d.unc       = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr    = req_write;
                    d.upper = req_addr[0];
                    d.blk   = req_addr[BLK_AW:1];
                    d.wdata = req_wdata;
                    d.rd_en = 1'b1;
                    d.st    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                d.st = ST_CHECK;
            end
            ST_CHECK: begin
                d.corr = dec_corr;
                d.unc  = dec_unc;
                if (q.wr) begin
                    d.cw_out = enc_cw;
                    d.wr_en  = 1'b1;
                    d.st     = ST_WBACK;
                end else begin
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = q.upper ? dec_data[DATA_W-1:HALF_W]
                                          : dec_data[HALF_W-1:0];
                    d.st        = ST_IDLE;
                end
            end
            ST_WBACK: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign rsp_valid  = q.rsp_valid;
    assign rsp_rdata  = q.rsp_data;
    assign corr_evt   = q.corr;
    assign uncorr_evt = q.unc;
    assign mem_rd_en  = q.rd_en;
    assign mem_wr_en  = q.wr_en;
    assign mem_addr   = q.blk;
    assign mem_wdata  = q.cw_out;

endmodule

// File: rtl/odsec_rmw_chk.sv
module odsec_rmw_chk #(
    parameter int BLK_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              corr_evt,
    input logic              uncorr_evt,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [BLK_AW-1:0] mem_addr
);

    p_fetch_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_en && !req_ready));

    p_fetch_only_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> $past(req_valid && req_ready));

    p_rsp_returns_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready && !mem_wr_en));

    p_wb_follows_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2));

    p_wb_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (!req_ready ##1 req_ready));

    p_port_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd_en, mem_wr_en}) <= 1);

    p_corr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        corr_evt |=> !corr_evt);

    p_corr_with_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        corr_evt |-> (rsp_valid || mem_wr_en));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_evt && uncorr_evt));

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

endmodule

bind odsec_rmw odsec_rmw_chk #(.BLK_AW(BLK_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .corr_evt   (corr_evt),
    .uncorr_evt (uncorr_evt),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr)
);

// File: tb/odsec_rmw_tb_top.sv
`timescale 1ns/1ps
module odsec_rmw_tb_top;

    localparam int HALF_W = 64;
    localparam int CHK_W  = 8;
    localparam int BLK_AW = 4;
    localparam int CW_W   = 2 * HALF_W + CHK_W;
    localparam int NBLK   = 1 << BLK_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [BLK_AW:0]   req_addr = '0;
    logic [HALF_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [HALF_W-1:0] rsp_rdata;
    logic              corr_evt;
    logic              uncorr_evt;
    logic              mem_rd_en;
    logic              mem_wr_en;
    logic [BLK_AW-1:0] mem_addr;
    logic [CW_W-1:0]   mem_wdata;
    logic [CW_W-1:0]   mem_rdata;

    always #2.5 clk = ~clk;

    odsec_rmw #(.HALF_W(HALF_W), .CHK_W(CHK_W), .BLK_AW(BLK_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .corr_evt(corr_evt),
        .uncorr_evt(uncorr_evt), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Behavioural array with a fault-injection port.
    logic [CW_W-1:0]   arr [NBLK];
    logic [CW_W-1:0]   rd_q;
    logic              inj_en = 1'b0;
    logic [BLK_AW-1:0] inj_addr = '0;
    logic [CW_W-1:0]   inj_mask = '0;
    int                wr_seen = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) arr[i] <= '0;
            rd_q <= '0;
        end else begin
            if (mem_rd_en) rd_q <= arr[mem_addr];
            if (mem_wr_en) begin
                arr[mem_addr] <= mem_wdata;
                wr_seen <= wr_seen + 1;
            end
            if (inj_en) arr[inj_addr] <= arr[inj_addr] ^ inj_mask;
        end
    end
    assign mem_rdata = rd_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [CW_W-1:0] act, input logic [CW_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic              obs_rden, obs_rdy1, obs_rdy2, obs_rdy3, obs_rdy4;
    logic              obs_rsp, obs_corr, obs_unc, obs_wren;
    logic [BLK_AW-1:0] obs_addr;
    logic [HALF_W-1:0] obs_data;

    task automatic run_op(input logic wr, input logic [BLK_AW:0] addr, input logic [HALF_W-1:0] data);
        @(negedge clk);
        req_write = wr; req_addr = addr; req_wdata = data; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        obs_rden = mem_rd_en; obs_addr = mem_addr; obs_rdy1 = req_ready;
        @(negedge clk);
        obs_rdy2 = req_ready;
        @(negedge clk);
        obs_rsp = rsp_valid; obs_data = rsp_rdata; obs_corr = corr_evt;
        obs_unc = uncorr_evt; obs_wren = mem_wr_en; obs_rdy3 = req_ready;
        obs_rdy4 = 1'b1;
        if (wr) begin
            @(negedge clk);
            obs_rdy4 = req_ready;
        end
    endtask

    task automatic inject(input logic [BLK_AW-1:0] a, input logic [CW_W-1:0] m);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    typedef struct packed {
        logic            wr;
        logic [BLK_AW:0] addr;
        logic [HALF_W-1:0] data;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, 5'd2,  64'hA5A5_A5A5_A5A5_A5A5},
        '{1'b1, 5'd3,  64'h0123_4567_89AB_CDEF},
        '{1'b0, 5'd2,  64'hA5A5_A5A5_A5A5_A5A5},
        '{1'b0, 5'd3,  64'h0123_4567_89AB_CDEF},
        '{1'b1, 5'd2,  64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b0, 5'd3,  64'h0123_4567_89AB_CDEF},
        '{1'b0, 5'd2,  64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b1, 5'd31, 64'h8000_0000_0000_0001},
        '{1'b0, 5'd30, 64'h0},
        '{1'b0, 5'd31, 64'h8000_0000_0000_0001}
    };

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", CW_W'(req_ready), 1);
        chk("R1 strobes in reset", CW_W'({rsp_valid, corr_evt, uncorr_evt, mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", CW_W'(req_ready), 1);
        chk("R1 strobes after reset", CW_W'({rsp_valid, corr_evt, uncorr_evt, mem_rd_en, mem_wr_en}), 0);

        // Table walk: R3, R4, R9
        for (int i = 0; i < 10; i++) begin
            run_op(VEC[i].wr, VEC[i].addr, VEC[i].data);
            chk("R3 fetch strobe", CW_W'(obs_rden), 1);
            chk("R3 block address", CW_W'(obs_addr), CW_W'(VEC[i].addr[BLK_AW:1]));
            chk("R9 busy", CW_W'({obs_rdy1, obs_rdy2}), 0);
            if (VEC[i].wr) begin
                chk("R4 write-back strobe", CW_W'(obs_wren), 1);
                chk("R9 write still busy", CW_W'({obs_rdy3, obs_rsp}), 0);
                chk("R9 ready after write", CW_W'(obs_rdy4), 1);
            end else begin
                chk("R3 response strobe", CW_W'({obs_rsp, obs_rdy3, obs_wren}), CW_W'(3'b110));
                chk("R3 read data", CW_W'(obs_data), CW_W'(VEC[i].data));
                chk("R5 no correction on clean word", CW_W'({obs_corr, obs_unc}), 0);
            end
        end

        // R2: stored layout
        run_op(1'b1, 5'd0, 64'h1);
        chk("R2 codeword of data 0x1", arr[0], CW_W'(136'h7));
        run_op(1'b1, 5'd0, 64'h11);
        chk("R2 codeword of data 0x11", arr[0], CW_W'(136'h186));

        // R5: single-bit errors corrected on read, error not written back
        inject(4'd0, CW_W'(1) << 100);
        run_op(1'b0, 5'd1, 64'h0);
        chk("R5 upper half repaired", CW_W'(obs_data), 0);
        chk("R5 corr pulse", CW_W'({obs_rsp, obs_corr, obs_unc}), CW_W'(3'b110));
        run_op(1'b0, 5'd0, 64'h0);
        chk("R5 lower half repaired", CW_W'(obs_data), CW_W'(64'h11));
        chk("R5 corr pulse again", CW_W'(obs_corr), 1);
        @(negedge clk);
        chk("R5 corr lasts one cycle", CW_W'(corr_evt), 0);
        inject(4'd1, CW_W'(1) << 63);
        run_op(1'b0, 5'd2, 64'h0);
        chk("R5 check-bit flip repaired", CW_W'(obs_data), CW_W'(64'hFFFF_FFFF_FFFF_FFFF));
        chk("R5 check-bit flip flagged", CW_W'({obs_corr, obs_unc}), CW_W'(2'b10));

        // R6: repair before merge
        run_op(1'b1, 5'd3, 64'hDEAD_BEEF_0BAD_F00D);
        chk("R6 corr with write-back", CW_W'({obs_wren, obs_corr}), CW_W'(2'b11));
        run_op(1'b0, 5'd2, 64'h0);
        chk("R6 kept half", CW_W'(obs_data), CW_W'(64'hFFFF_FFFF_FFFF_FFFF));
        chk("R6 kept half clean", CW_W'(obs_corr), 0);
        run_op(1'b0, 5'd3, 64'h0);
        chk("R6 new half", CW_W'(obs_data), CW_W'(64'hDEAD_BEEF_0BAD_F00D));
        chk("R6 new half clean", CW_W'(obs_corr), 0);

        // R7: syndrome beyond the word
        inject(4'd2, (CW_W'(1) << 127) | (CW_W'(1) << 8));
        run_op(1'b0, 5'd4, 64'h0);
        chk("R7 raw lower data", CW_W'(obs_data), CW_W'(64'h10));
        chk("R7 flags", CW_W'({obs_corr, obs_unc}), CW_W'(2'b01));
        run_op(1'b0, 5'd5, 64'h0);
        chk("R7 upper untouched", CW_W'(obs_data), 0);
        chk("R7 flags upper", CW_W'({obs_corr, obs_unc}), CW_W'(2'b01));

        // R8: requests while busy are ignored
        begin
            int wr_before;
            wr_before = wr_seen;
            @(negedge clk);
            req_write = 1'b0; req_addr = 5'd2; req_valid = 1'b1;
            @(negedge clk);
            req_write = 1'b1; req_wdata = 64'h0;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R8 first read served", CW_W'({rsp_valid, rsp_rdata}),
                CW_W'({1'b1, 64'hFFFF_FFFF_FFFF_FFFF}));
            repeat (4) @(negedge clk);
            chk("R8 no write-back", CW_W'(wr_seen - wr_before), 0);
            chk("R8 no fetch", CW_W'(mem_rd_en), 0);
            run_op(1'b0, 5'd2, 64'h0);
            chk("R8 data unchanged", CW_W'(obs_data), CW_W'(64'hFFFF_FFFF_FFFF_FFFF));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule